// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Enable Gating

This block supervises software through a windowed watchdog. After the supply becomes valid, each supervision cycle starts with a closed window and continues into an open window. Software signals that it is alive by driving a falling edge on the service input. Servicing inside the open window restarts the cycle. Servicing inside the closed window, or not servicing at all, produces a fixed-width active-low reset pulse. Because an early service also counts as a fault, a program stuck in a tight loop that still reaches the service routine is caught too.

A second active-low output, the system enable, gates critical actuators. It is held off during any reset. After a reset it stays off until software has serviced the watchdog correctly several times in a row. The block also models power sequencing from a digital supply-good flag. When the flag rises, a power-on delay holds reset low. A supply dropout that lasts longer than a deglitch interval forces reset low and enable off at once. Dropouts shorter than that interval are filtered out. All intervals are parameters counted in system clock cycles.

Top module: `wdw_supervisor`

## Requirements
- R1: A service edge that reaches the timer while the open window is current restarts the closed window from zero, with no reset pulse. The service input is active on its falling edge, passes through a two-flop synchronizer, and reaches the timer on the third rising clock edge after the input falls.
- R2: A service edge that reaches the timer during the closed window drives res_n low on that edge for exactly WDR_CYC cycles, with en_n high.
- R3: If no service edge arrives, res_n goes low CW_CYC+OW_CYC cycles after the closed window starts and stays low for exactly WDR_CYC cycles. The closed window then restarts from zero.
- R4: While no valid service arrives, res_n repeats as a periodic wave with period CW_CYC+OW_CYC+WDR_CYC.
- R5: en_n goes low on the edge on which the third consecutive valid service lands, and not before.
- R6: After reset, and while supply-good is low, res_n is low and en_n is high. When supply-good rises, res_n stays low for POR_CYC+1 cycles, and service edges have no effect during that time. The closed window starts when res_n rises.
- R7: When supply-good has been low on BOD_CYC consecutive edges, res_n goes low and en_n goes high on the last of those edges. Service edges are then ignored until supply-good returns and a new power-on delay completes.
- R8: Every reset pulse, whatever its cause, clears the count of consecutive valid services. After a pulse, en_n stays high until three new valid services have landed.
- R9: en_n is high in every cycle in which res_n is low.
- R10: A supply-good low interval shorter than BOD_CYC cycles changes neither output nor the timer phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| svc_n | input | 1 | Service input from software; a falling edge is a service |
| pwr_ok | input | 1 | Digital supply-good flag, synchronous to clk |
| res_n | output | 1 | Active-low system reset |
| en_n | output | 1 | Active-low system enable |

## Verification
On every cycle, the checker enforces the following: the enable is off whenever reset is low, reset pulses are never shorter than the watchdog pulse width, a long supply dropout always holds reset low, enable is still off when reset releases, and enable only falls while reset is high. The window boundaries need the bench's scenarios. These scenarios cover services on the first and last open cycles, an early service on the last closed cycle, the exact pulse timing and the repetition period, the count of three services, the filtering of short glitches, and service edges that are ignored during power-on and after a brown-out.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    WIN_CLOSED = 2'd0,
    WIN_OPEN   = 2'd1,
    WIN_PULSE  = 2'd2
  } win_state_e;

  typedef enum logic [1:0] {
    PWR_OFF = 2'd0,
    PWR_POR = 2'd1,
    PWR_RUN = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/wdw_svc_sync.sv
module wdw_svc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_n,
  output logic svc_fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] shreg;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shreg[0] <= 1'b1;
          else        shreg[0] <= svc_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shreg[i] <= 1'b1;
          else        shreg[i] <= shreg[i-1];
        end
      end
    end
  endgenerate

  assign svc_fall = shreg[STAGES] & ~shreg[STAGES-1];
endmodule

// File: rtl/wdw_pwr_mon.sv
module wdw_pwr_mon
  import wdw_pkg::*;
#(
  parameter int POR_CYC = 1000,
  parameter int BOD_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic run
);
  localparam int POR_W = (POR_CYC > 1) ? $clog2(POR_CYC) : 1;
  localparam int BOD_W = (BOD_CYC > 1) ? $clog2(BOD_CYC) : 1;
  localparam logic [POR_W-1:0] POR_LAST = POR_W'(POR_CYC - 1);
  localparam logic [BOD_W-1:0] BOD_LAST = BOD_W'(BOD_CYC - 1);

  pwr_state_e       state;
  logic [POR_W-1:0] por_cnt;
  logic [BOD_W-1:0] low_cnt;
  logic             brown;

  // brown-out once this edge would be the BOD_CYC-th consecutive low sample
  assign brown = ~pwr_ok & (low_cnt == BOD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (pwr_ok) begin
      low_cnt <= '0;
    end else if (low_cnt != BOD_LAST) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PWR_OFF;
      por_cnt <= '0;
    end else begin
      unique case (state)
        PWR_OFF: begin
          por_cnt <= '0;
          if (pwr_ok) state <= PWR_POR;
        end
        PWR_POR: begin
          if (brown) begin
            state <= PWR_OFF;
          end else if (por_cnt == POR_LAST) begin
            state <= PWR_RUN;
          end else begin
            por_cnt <= por_cnt + 1'b1;
          end
        end
        PWR_RUN: begin
          if (brown) state <= PWR_OFF;
        end
        default: state <= PWR_OFF;
      endcase
    end
  end

  assign run = (state == PWR_RUN);
endmodule

// File: rtl/wdw_win_timer.sv
module wdw_win_timer
  import wdw_pkg::*;
#(
  parameter int CW_CYC  = 4000,
  parameter int OW_CYC  = 4000,
  parameter int WDR_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic svc_fall,
  output logic pulse_act,
  output logic good_svc
);
  localparam int MAX_CYC = (CW_CYC > OW_CYC) ?
                           ((CW_CYC > WDR_CYC) ? CW_CYC : WDR_CYC) :
                           ((OW_CYC > WDR_CYC) ? OW_CYC : WDR_CYC);
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] CW_LAST  = CNT_W'(CW_CYC - 1);
  localparam logic [CNT_W-1:0] OW_LAST  = CNT_W'(OW_CYC - 1);
  localparam logic [CNT_W-1:0] WDR_LAST = CNT_W'(WDR_CYC - 1);

  win_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign good_svc  = run & (state == WIN_OPEN) & svc_fall;
  assign pulse_act = (state == WIN_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WIN_CLOSED;
      cnt   <= '0;
    end else if (!run) begin
      state <= WIN_CLOSED;
      cnt   <= '0;
    end else begin
      unique case (state)
        WIN_CLOSED: begin
          if (svc_fall) begin
            state <= WIN_PULSE;
            cnt   <= '0;
          end else if (cnt == CW_LAST) begin
            state <= WIN_OPEN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WIN_OPEN: begin
          if (svc_fall) begin
            state <= WIN_CLOSED;
            cnt   <= '0;
          end else if (cnt == OW_LAST) begin
            state <= WIN_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WIN_PULSE: begin
          if (cnt == WDR_LAST) begin
            state <= WIN_CLOSED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= WIN_CLOSED;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wdw_en_gate.sv
module wdw_en_gate #(
  parameter int GOOD_NEED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pulse_act,
  input  logic good_svc,
  output logic en_ok
);
  localparam int GW = $clog2(GOOD_NEED + 1);
  localparam logic [GW-1:0] NEED = GW'(GOOD_NEED);

  logic [GW-1:0] good_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
    end else if (!run || pulse_act) begin
      good_cnt <= '0;
    end else if (good_svc && good_cnt != NEED) begin
      good_cnt <= good_cnt + 1'b1;
    end
  end

  assign en_ok = (good_cnt == NEED);
endmodule

// File: rtl/wdw_supervisor.sv
module wdw_supervisor #(
  parameter int CW_CYC    = 4000,
  parameter int OW_CYC    = 4000,
  parameter int WDR_CYC   = 200,
  parameter int POR_CYC   = 1000,
  parameter int BOD_CYC   = 64,
  parameter int GOOD_NEED = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_n,
  input  logic pwr_ok,
  output logic res_n,
  output logic en_n
);
  logic svc_fall;
  logic run;
  logic pulse_act;
  logic good_svc;
  logic en_ok;

  wdw_svc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_n    (svc_n),
    .svc_fall (svc_fall)
  );

  wdw_pwr_mon #(.POR_CYC(POR_CYC), .BOD_CYC(BOD_CYC)) u_pwr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .run    (run)
  );

  wdw_win_timer #(.CW_CYC(CW_CYC), .OW_CYC(OW_CYC), .WDR_CYC(WDR_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .svc_fall  (svc_fall),
    .pulse_act (pulse_act),
    .good_svc  (good_svc)
  );

  wdw_en_gate #(.GOOD_NEED(GOOD_NEED)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pulse_act (pulse_act),
    .good_svc  (good_svc),
    .en_ok     (en_ok)
  );

  assign res_n = run & ~pulse_act;
  assign en_n  = ~(en_ok & res_n);
endmodule

// File: rtl/wdw_supervisor_chk.sv
module wdw_supervisor_chk #(
  parameter int WDR_CYC = 200,
  parameter int BOD_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic res_n,
  input logic en_n
);
  logic [15:0] low_run;
  logic [15:0] pwr_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      pwr_low <= '0;
    end else begin
      if (res_n)                low_run <= '0;
      else if (low_run != '1)   low_run <= low_run + 1'b1;
      if (pwr_ok)               pwr_low <= '0;
      else if (pwr_low != '1)   pwr_low <= pwr_low + 1'b1;
    end
  end

  // R9
  en_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_n |-> en_n);

  // R8
  en_off_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_n) |-> en_n);

  // R5
  en_falls_outside_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_n) |-> (res_n && $past(res_n)));

  // R3
  pulse_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_n) |-> (low_run >= 16'(WDR_CYC)));

  // R7
  brownout_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_low >= 16'(BOD_CYC)) |-> !res_n);
endmodule

bind wdw_supervisor wdw_supervisor_chk #(.WDR_CYC(WDR_CYC), .BOD_CYC(BOD_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pwr_ok (pwr_ok),
  .res_n  (res_n),
  .en_n   (en_n)
);

// File: tb/tb_wdw_supervisor.sv
module tb_wdw_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int OW  = 6;
  localparam int WDR = 3;
  localparam int POR = 10;
  localparam int BOD = 4;
  localparam int PER = CW + OW + WDR;

  logic clk = 1'b0;
  logic rst_n, svc_n, pwr_ok;
  logic res_n, en_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdw_supervisor #(
    .CW_CYC(CW), .OW_CYC(OW), .WDR_CYC(WDR), .POR_CYC(POR),
    .BOD_CYC(BOD), .GOOD_NEED(3), .SYNC_STG(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .svc_n(svc_n), .pwr_ok(pwr_ok),
    .res_n(res_n), .en_n(en_n)
  );

  typedef struct {
    int    at;
    logic  res;
    logic  en;
    string tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard entries are kept sorted by cycle
  task automatic expect_at(input int at, input logic r, input logic e, input string tag);
    exp_t it;
    int pos;
    it.at = at; it.res = r; it.en = e; it.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin pos = i; break; end
    end
    sb.insert(pos, it);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // service edge acting on timer edge e
  task automatic svc_at(input int e);
    wait_cyc(e - 3);
    svc_n = 1'b0;
    wait_cyc(e);
    svc_n = 1'b1;
  endtask

  // monitor: compares outputs at the negedge of the expected cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      n_cmp++;
      if (it.at != cyc || res_n !== it.res || en_n !== it.en) begin
        n_bad++;
        $display("FAIL %s cyc=%0d: res_n/en_n actual %b/%b expected %b/%b (at %0d)",
                 it.tag, cyc, res_n, en_n, it.res, it.en, it.at);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t, rs, b, e1, e2, e3, e4, e5, e6, t2;
    rst_n = 1'b0; pwr_ok = 1'b0; svc_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 1'b0, 1'b1, "R6 reset state");
    wait_cyc(cyc + 2);
    rst_n = 1'b1;
    expect_at(cyc + 2, 1'b0, 1'b1, "R6 supply low");
    wait_cyc(cyc + 3);

    // power-up with a service edge inside the delay
    t = cyc; pwr_ok = 1'b1; rs = t + POR + 1;
    expect_at(rs - 1, 1'b0, 1'b1, "R6 por held");
    expect_at(rs,     1'b1, 1'b1, "R6 por release");
    // R6: early service during delay must not shift the timeout
    b = rs; t2 = b + CW + OW;
    expect_at(t2 - 1,        1'b1, 1'b1, "R3 before timeout");
    expect_at(t2,            1'b0, 1'b1, "R3 timeout pulse");
    expect_at(t2 + WDR - 1,  1'b0, 1'b1, "R3 pulse last");
    expect_at(t2 + WDR,      1'b1, 1'b1, "R3 pulse end");
    expect_at(t2 + PER - 1,  1'b1, 1'b1, "R4 period high");
    expect_at(t2 + PER,      1'b0, 1'b1, "R4 period low");
    svc_at(t + 5);
    b = t2 + PER + WDR;
    wait_cyc(b);

    // three valid services: first and last open cycle boundaries
    e1 = b + CW + 1;
    expect_at(e1,          1'b1, 1'b1, "R1 first open cycle");
    expect_at(e1 + OW - 1, 1'b1, 1'b1, "R1 no timeout after service");
    svc_at(e1);
    e2 = e1 + CW + OW;
    expect_at(e2, 1'b1, 1'b1, "R5 two services en off");
    svc_at(e2);
    e3 = e2 + CW + 3;
    expect_at(e3 - 1, 1'b1, 1'b1, "R5 before third");
    expect_at(e3,     1'b1, 1'b0, "R5 third service");
    svc_at(e3);

    // short supply glitch during closed window
    b = e3;
    e4 = b + CW + 2;
    expect_at(b + BOD, 1'b1, 1'b0, "R10 glitch ignored");
    expect_at(e4,      1'b1, 1'b0, "R10 phase kept");
    wait_cyc(b + 1);
    pwr_ok = 1'b0;
    wait_cyc(b + BOD);
    pwr_ok = 1'b1;
    svc_at(e4);

    // early service on last closed cycle
    e5 = e4 + CW;
    expect_at(e5 - 1,       1'b1, 1'b0, "R2 before early");
    expect_at(e5,           1'b0, 1'b1, "R2 early pulse");
    expect_at(e5 + WDR - 1, 1'b0, 1'b1, "R2 pulse width");
    expect_at(e5 + WDR,     1'b1, 1'b1, "R8 en off after pulse");
    svc_at(e5);
    e6 = e5 + WDR + CW + 1;
    expect_at(e6, 1'b1, 1'b1, "R8 count restarted");
    svc_at(e6);

    // brown-out
    wait_cyc(e6 + 1);
    t = cyc; pwr_ok = 1'b0;
    expect_at(t + BOD - 1, 1'b1, 1'b1, "R7 before brownout");
    expect_at(t + BOD,     1'b0, 1'b1, "R7 brownout");
    expect_at(t + BOD + 5, 1'b0, 1'b1, "R7 service ignored");
    svc_at(t + BOD + 3);
    wait_cyc(t + BOD + 8);
    t = cyc; pwr_ok = 1'b1; rs = t + POR + 1;
    expect_at(rs - 1, 1'b0, 1'b1, "R7 new por");
    expect_at(rs,     1'b1, 1'b1, "R7 restart");
    expect_at(rs + CW + OW, 1'b0, 1'b1, "R7 timer restarted");
    wait_cyc(rs + CW + 2);
    expect_at(rs + CW + 3, 1'b1, 1'b1, "R8 cleared by brownout");
    wait_cyc(rs + CW + OW + 2);

    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule